// File: doc/BRIEF.md
# Time-Ordered Response Queue

This block holds response tags that may only be released at a given future cycle, and hands them out in order of that cycle. A producer offers a tag together with the absolute cycle at which the response may leave. The block keeps a small sorted array of pending entries, so the earliest entry is always at the head. Once the running cycle count, supplied on `cur_time`, reaches the head's ready time, the head is shown on the dequeue side. A consumer takes it with a valid/ready handshake.

The head's ready time is held in a separate release register. That register is loaded only when a different entry becomes the head: an insert into an empty queue, an insert that lands ahead of every pending entry, or a removal that promotes the next entry. Three kinds of request never enter the array. Requests that need no response are discarded without any signal. Requests whose ready time is already in the past raise `late_err`. Requests that arrive while the array is full and nothing leaves in the same cycle raise `overflow`. The empty flag is meant for a drain controller that waits for all responses to leave.

Top module: `resp_time_queue`

## Requirements
- R1: During and right after reset the queue is empty: `empty`=1, `full`=0, `deq_valid`=0, `late_err`=0, `overflow`=0.
- R2: An entry accepted into an empty queue becomes the head. From the next cycle on, `deq_time` equals its ready time and `deq_tag` equals its tag.
- R3: An accepted entry whose ready time is greater than or equal to the ready time of the last pending entry goes behind all pending entries.
- R4: An accepted entry whose ready time equals the ready time of one or more pending entries leaves after all of them.
- R5: Any other accepted entry is placed just ahead of the first pending entry with a strictly greater ready time. When that position is the head, `deq_time` shows the new, earlier ready time in the next cycle.
- R6: `deq_valid` is 1 exactly when the queue is not empty and `cur_time` is greater than or equal to the head's ready time. `deq_tag` and `deq_time` always show the head entry.
- R7: The head is removed at a clock edge where `deq_valid` and `deq_ready` are both 1. While `deq_ready` is 0, the head and `deq_valid` stay unchanged.
- R8: A request with `enq_no_resp`=0 and `enq_time` < `cur_time` is dropped. `late_err` is 1 for the following cycle.
- R9: A request with `enq_no_resp`=1 is discarded whatever its time. It changes no entry and raises neither `late_err` nor `overflow`.
- R10: A request for a valid on-time entry while the queue is full and no removal takes place in the same cycle is dropped, and `overflow` is 1 for the following cycle. If a removal takes place in the same cycle, the entry is accepted.
- R11: `empty` is 1 exactly when no entries are pending. `full` is 1 exactly when DEPTH entries are pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_time | input | TIME_W | Current cycle count; must not decrease |
| enq_valid | input | 1 | Enqueue request present |
| enq_tag | input | TAG_W | Tag of the response |
| enq_time | input | TIME_W | Cycle at which the response may leave |
| enq_no_resp | input | 1 | Request needs no response; discard it |
| deq_valid | output | 1 | Head entry is due |
| deq_tag | output | TAG_W | Tag of the head entry |
| deq_time | output | TIME_W | Ready time of the head entry (release register) |
| deq_ready | input | 1 | Consumer takes the head entry |
| full | output | 1 | DEPTH entries pending |
| empty | output | 1 | No entries pending |
| late_err | output | 1 | Pulse: previous request had a past ready time |
| overflow | output | 1 | Pulse: previous request was refused because the queue was full |

## Verification
The checker runs on every cycle and covers the local rules:
- `full` and `empty` are never both 1.
- No due head is shown on an empty queue or before its ready time.
- A stalled head stays put.
- Each error pulse traces back to its cause in the previous cycle.
- A discarded request raises no pulse.
- An insert into an empty queue loads the release register.

Sort order cannot be seen in a single cycle: ties leaving in arrival order, an insert landing mid-array, or an early entry taking over the head. Those show only in the order in which tags leave. The bench's reference model and its directed sequences check that order.

// File: rtl/rsq_pkg.sv
// Package: shared types for the time-ordered response queue.
// Assumes nothing beyond standard SystemVerilog.
package rsq_pkg;

    // What happens to an enqueue request this cycle
    typedef enum logic [1:0] {
        ENQ_IDLE = 2'd0,  // nothing offered, or no response needed
        ENQ_TAKE = 2'd1,  // entry goes into the array
        ENQ_LATE = 2'd2,  // ready time already passed
        ENQ_FULL = 2'd3   // no room and nothing leaves
    } enq_disp_e;

endpackage

// File: rtl/rsq_classify.sv
// Module: decides the fate of an enqueue request.
// Assumes: pop already reflects this cycle's completed handshake.
module rsq_classify #(
    parameter int TIME_W = 16
) (
    input  logic              enq_valid,
    input  logic              enq_no_resp,
    input  logic [TIME_W-1:0] enq_time,
    input  logic [TIME_W-1:0] cur_time,
    input  logic              full,
    input  logic              pop,
    output rsq_pkg::enq_disp_e disp
);
    import rsq_pkg::*;

    // Priority: discard, then lateness, then capacity
    always_comb begin
        if (!enq_valid || enq_no_resp) begin
            disp = ENQ_IDLE;
        end else if (enq_time < cur_time) begin
            disp = ENQ_LATE;
        end else if (full && !pop) begin
            disp = ENQ_FULL;
        end else begin
            disp = ENQ_TAKE;
        end
    end
endmodule

// File: rtl/rsq_locate.sv
// Module: finds the insert position of a new ready time in the sorted array.
// The position is the number of pending entries whose time is <= the new
// time, so ties land behind existing equal entries.
// Assumes: slots [0, count) are valid and sorted ascending.
module rsq_locate #(
    parameter int DEPTH  = 8,
    parameter int TIME_W = 16,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic [DEPTH-1:0][TIME_W-1:0] times,
    input  logic [CW-1:0]                count,
    input  logic [TIME_W-1:0]            new_time,
    output logic [CW-1:0]                pos
);
    logic [DEPTH-1:0] not_later;

    // One comparator per slot: pending and not later than the new time
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign not_later[i] = (CW'(i) < count) && (times[i] <= new_time);
    end

    // Population count of the comparator flags
    always_comb begin
        pos = '0;
        for (int i = 0; i < DEPTH; i++) begin
            pos = pos + CW'(not_later[i]);
        end
    end
endmodule

// File: rtl/rsq_store.sv
// Module: the sorted entry array with shift-out at the head and shift-insert.
// Assumes: push is only asserted when room exists after a pop; ins_pos is
// already adjusted for a same-cycle pop and lies within [0, count-pop].
module rsq_store #(
    parameter int DEPTH  = 8,
    parameter int TAG_W  = 8,
    parameter int TIME_W = 16,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic                         pop,
    input  logic [CW-1:0]                ins_pos,
    input  logic [TAG_W-1:0]             new_tag,
    input  logic [TIME_W-1:0]            new_time,
    output logic [DEPTH-1:0][TAG_W-1:0]  tags,
    output logic [DEPTH-1:0][TIME_W-1:0] times,
    output logic [CW-1:0]                count
);
    logic [DEPTH-1:0][TAG_W-1:0]  tag_sh;
    logic [DEPTH-1:0][TIME_W-1:0] time_sh;
    logic [DEPTH-1:0][TAG_W-1:0]  tag_nx;
    logic [DEPTH-1:0][TIME_W-1:0] time_nx;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        // Array after the optional removal of the head
        if (i + 1 < DEPTH) begin : g_mid
            assign tag_sh[i]  = pop ? tags[i+1]  : tags[i];
            assign time_sh[i] = pop ? times[i+1] : times[i];
        end else begin : g_last
            assign tag_sh[i]  = tags[i];
            assign time_sh[i] = times[i];
        end

        // Slot content after the optional insertion
        if (i == 0) begin : g_first
            always_comb begin
                tag_nx[i]  = tag_sh[i];
                time_nx[i] = time_sh[i];
                if (push && ins_pos == '0) begin
                    tag_nx[i]  = new_tag;
                    time_nx[i] = new_time;
                end
            end
        end else begin : g_rest
            always_comb begin
                tag_nx[i]  = tag_sh[i];
                time_nx[i] = time_sh[i];
                if (push) begin
                    if (ins_pos == CW'(i)) begin
                        tag_nx[i]  = new_tag;
                        time_nx[i] = new_time;
                    end else if (ins_pos < CW'(i)) begin
                        tag_nx[i]  = tag_sh[i-1];
                        time_nx[i] = time_sh[i-1];
                    end
                end
            end
        end
    end

    // Entry storage; contents beyond count are don't-care
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tags  <= '0;
            times <= '0;
        end else if (push || pop) begin
            tags  <= tag_nx;
            times <= time_nx;
        end
    end

    // Occupancy counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            count <= count + CW'(push) - CW'(pop);
        end
    end
endmodule

// File: rtl/rsq_release.sv
// Module: release register holding the head's ready time, and the due test.
// Assumes: cur_time never decreases; load is asserted whenever the head
// entry changes identity.
module rsq_release #(
    parameter int TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [TIME_W-1:0] load_time,
    input  logic [TIME_W-1:0] cur_time,
    input  logic              empty,
    output logic [TIME_W-1:0] arm_time,
    output logic              due
);
    // Re-arm only when a new head appears
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_time <= '0;
        end else if (load) begin
            arm_time <= load_time;
        end
    end

    // Head is due once the running count reaches the armed time
    assign due = !empty && (cur_time >= arm_time);
endmodule

// File: rtl/resp_time_queue.sv
// Module: time-ordered response queue (top).
// Holds up to DEPTH tags sorted by ready time and releases the head once
// cur_time reaches it. Assumes DEPTH >= 2 and that cur_time rises by at
// most one per cycle without wrapping during the queue's use.
module resp_time_queue #(
    parameter int DEPTH  = 8,
    parameter int TAG_W  = 8,
    parameter int TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] cur_time,
    input  logic              enq_valid,
    input  logic [TAG_W-1:0]  enq_tag,
    input  logic [TIME_W-1:0] enq_time,
    input  logic              enq_no_resp,
    output logic              deq_valid,
    output logic [TAG_W-1:0]  deq_tag,
    output logic [TIME_W-1:0] deq_time,
    input  logic              deq_ready,
    output logic              full,
    output logic              empty,
    output logic              late_err,
    output logic              overflow
);
    import rsq_pkg::*;

    localparam int CW = $clog2(DEPTH + 1);

    logic [DEPTH-1:0][TAG_W-1:0]  tags;
    logic [DEPTH-1:0][TIME_W-1:0] times;
    logic [CW-1:0]                count;
    logic [CW-1:0]                pos;
    logic [CW-1:0]                ins_pos;
    enq_disp_e                    disp;
    logic                         pop;
    logic                         push;
    logic                         new_head;
    logic                         arm_load;
    logic [TIME_W-1:0]            arm_val;

    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));
    assign pop   = deq_valid && deq_ready;
    assign push  = (disp == ENQ_TAKE);

    // A pop only happens for a head at or before cur_time <= enq_time, so the
    // head was counted in pos and the subtraction cannot underflow
    assign ins_pos  = pos - CW'(pop);
    assign new_head = push && (ins_pos == '0);

    // Release register reload: a new earliest entry, or the next one promoted
    assign arm_load = new_head || pop;
    assign arm_val  = new_head ? enq_time : times[1];

    rsq_classify #(.TIME_W(TIME_W)) u_classify (
        .enq_valid   (enq_valid),
        .enq_no_resp (enq_no_resp),
        .enq_time    (enq_time),
        .cur_time    (cur_time),
        .full        (full),
        .pop         (pop),
        .disp        (disp)
    );

    rsq_locate #(.DEPTH(DEPTH), .TIME_W(TIME_W)) u_locate (
        .times    (times),
        .count    (count),
        .new_time (enq_time),
        .pos      (pos)
    );

    rsq_store #(.DEPTH(DEPTH), .TAG_W(TAG_W), .TIME_W(TIME_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .pop      (pop),
        .ins_pos  (ins_pos),
        .new_tag  (enq_tag),
        .new_time (enq_time),
        .tags     (tags),
        .times    (times),
        .count    (count)
    );

    rsq_release #(.TIME_W(TIME_W)) u_release (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (arm_load),
        .load_time (arm_val),
        .cur_time  (cur_time),
        .empty     (empty),
        .arm_time  (deq_time),
        .due       (deq_valid)
    );

    assign deq_tag = tags[0];

    // Error pulses, one cycle after the offending request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            late_err <= 1'b0;
            overflow <= 1'b0;
        end else begin
            late_err <= (disp == ENQ_LATE);
            overflow <= (disp == ENQ_FULL);
        end
    end
endmodule

// File: rtl/rsq_checker.sv
// Module: property checker for resp_time_queue, attached by bind.
// Assumes cur_time never decreases (the block's own input contract).
module rsq_checker #(
    parameter int DEPTH  = 8,
    parameter int TAG_W  = 8,
    parameter int TIME_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [TIME_W-1:0] cur_time,
    input logic              enq_valid,
    input logic [TIME_W-1:0] enq_time,
    input logic              enq_no_resp,
    input logic              deq_valid,
    input logic [TAG_W-1:0]  deq_tag,
    input logic [TIME_W-1:0] deq_time,
    input logic              deq_ready,
    input logic              full,
    input logic              empty,
    input logic              late_err,
    input logic              overflow
);
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty)); // R11

    AST_NO_EARLY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        deq_valid |-> (cur_time >= deq_time)); // R6

    AST_EMPTY_NOT_DUE: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !deq_valid); // R6

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_valid && !deq_ready) |=> (deq_valid && $stable(deq_tag) && $stable(deq_time))); // R7

    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(late_err && overflow)); // R8

    AST_LATE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        late_err |-> $past(enq_valid && !enq_no_resp && (enq_time < cur_time))); // R8

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> $past(full && !(deq_valid && deq_ready))); // R10

    AST_DISCARD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid && enq_no_resp) |=> (!late_err && !overflow)); // R9

    AST_FIRST_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && enq_valid && !enq_no_resp && (enq_time >= cur_time))
        |=> (!empty && (deq_time == $past(enq_time)))); // R2
endmodule

bind resp_time_queue rsq_checker #(
    .DEPTH  (DEPTH),
    .TAG_W  (TAG_W),
    .TIME_W (TIME_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cur_time    (cur_time),
    .enq_valid   (enq_valid),
    .enq_time    (enq_time),
    .enq_no_resp (enq_no_resp),
    .deq_valid   (deq_valid),
    .deq_tag     (deq_tag),
    .deq_time    (deq_time),
    .deq_ready   (deq_ready),
    .full        (full),
    .empty       (empty),
    .late_err    (late_err),
    .overflow    (overflow)
);

// File: tb/resp_time_queue_tb_top.sv
// Bench: behavioural reference model (a sorted queue) compared every cycle,
// plus directed sequences for ordering, stalls, drops and capacity.
module resp_time_queue_tb_top;
    localparam int DEPTH  = 8;
    localparam int TAG_W  = 8;
    localparam int TIME_W = 16;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [TIME_W-1:0] cur_time;
    logic              enq_valid;
    logic [TAG_W-1:0]  enq_tag;
    logic [TIME_W-1:0] enq_time;
    logic              enq_no_resp;
    logic              deq_valid;
    logic [TAG_W-1:0]  deq_tag;
    logic [TIME_W-1:0] deq_time;
    logic              deq_ready;
    logic              full;
    logic              empty;
    logic              late_err;
    logic              overflow;

    always #5 clk = ~clk;

    resp_time_queue #(.DEPTH(DEPTH), .TAG_W(TAG_W), .TIME_W(TIME_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cur_time(cur_time),
        .enq_valid(enq_valid), .enq_tag(enq_tag), .enq_time(enq_time),
        .enq_no_resp(enq_no_resp), .deq_valid(deq_valid), .deq_tag(deq_tag),
        .deq_time(deq_time), .deq_ready(deq_ready), .full(full), .empty(empty),
        .late_err(late_err), .overflow(overflow)
    );

    typedef struct { int t; int tag; } ent_t;
    ent_t q[$];
    int   popped[$];
    int   t = 0;
    int   errors = 0;
    int   checks = 0;
    bit   exp_late = 0;
    bit   exp_ovf = 0;
    bit   done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at t=%0d: actual=%0d expected=%0d", req, t, act, exp);
        end
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Compare all outputs with the model state
    task automatic compare();
        bit ev;
        ev = (q.size() > 0) && (t >= q[0].t);
        chk(empty == (q.size() == 0), "R11 empty", int'(empty), int'(q.size() == 0));
        chk(full == (q.size() == DEPTH), "R11 full", int'(full), int'(q.size() == DEPTH));
        chk(deq_valid == ev, "R6 deq_valid", int'(deq_valid), int'(ev));
        if (q.size() > 0) begin
            chk(int'(deq_tag) == q[0].tag, "R6 deq_tag", int'(deq_tag), q[0].tag);
            chk(int'(deq_time) == q[0].t, "R5 deq_time", int'(deq_time), q[0].t);
        end
        chk(late_err == exp_late, "R8 late_err", int'(late_err), int'(exp_late));
        chk(overflow == exp_ovf, "R10 overflow", int'(overflow), int'(exp_ovf));
    endtask

    // One cycle: compare, drive, advance model, move to next negedge
    task automatic cyc(input bit ev, input int tg, input int tm, input bit nr, input bit rd);
        bit pop;
        int idx;
        compare();
        enq_valid   = ev;
        enq_tag     = TAG_W'(tg);
        enq_time    = TIME_W'(tm);
        enq_no_resp = nr;
        deq_ready   = rd;
        pop = rd && (q.size() > 0) && (t >= q[0].t);
        exp_late = 0;
        exp_ovf  = 0;
        if (pop) begin
            popped.push_back(q[0].tag);
            void'(q.pop_front());
        end
        if (ev && !nr) begin
            if (tm < t) exp_late = 1;
            else if (q.size() == DEPTH) exp_ovf = 1;
            else begin
                idx = q.size();
                for (int k = 0; k < q.size(); k++) begin
                    if (q[k].t > tm) begin
                        idx = k;
                        break;
                    end
                end
                q.insert(idx, '{t: tm, tag: tg});
            end
        end
        @(posedge clk);
        @(negedge clk);
        t++;
        cur_time = TIME_W'(t);
        enq_valid = 0;
        deq_ready = 0;
        #1;
    endtask

    task automatic idle(input int n, input bit rd);
        for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, rd);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired at t=%0d: actual=hung expected=finished", t);
            summary();
            $finish;
        end
    end

    initial begin
        int b;
        rst_n = 0;
        cur_time = '0;
        enq_valid = 0;
        enq_tag = '0;
        enq_time = '0;
        enq_no_resp = 0;
        deq_ready = 0;
        repeat (3) begin
            @(posedge clk);
            @(negedge clk);
            t++;
            cur_time = TIME_W'(t);
        end
        #1;
        // R1: reset state
        chk(empty == 1 && full == 0 && deq_valid == 0, "R1 flags", {empty, full, deq_valid}, 3'b100);
        chk(late_err == 0 && overflow == 0, "R1 pulses", {late_err, overflow}, 0);
        rst_n = 1;

        // Ordering: first head, append, head insert, ties
        b = t;
        cyc(1, 1, b + 20, 0, 0);
        chk(int'(deq_time) == b + 20 && deq_tag == 8'd1, "R2 first head", int'(deq_time), b + 20);
        cyc(1, 2, b + 30, 0, 0);
        cyc(1, 3, b + 10, 0, 0);
        chk(int'(deq_time) == b + 10 && deq_tag == 8'd3, "R5 head re-armed", int'(deq_time), b + 10);
        chk(deq_valid == 0, "R6 not yet due", int'(deq_valid), 0);
        cyc(1, 4, b + 30, 0, 0);
        cyc(1, 5, b + 30, 0, 0);
        cyc(1, 6, b + 25, 0, 0);
        popped.delete();
        while (!empty && t < b + 200) cyc(0, 0, 0, 0, 1);
        chk(popped.size() == 6, "R3 drained count", popped.size(), 6);
        if (popped.size() == 6) begin
            chk(popped[0] == 3 && popped[1] == 1, "R5 early insert first", popped[0], 3);
            chk(popped[2] == 6, "R5 mid insert", popped[2], 6);
            chk(popped[3] == 2, "R3 appended order", popped[3], 2);
            chk(popped[4] == 4 && popped[5] == 5, "R4 ties keep arrival order", popped[4], 4);
        end

        // Stall: head held while ready is low
        cyc(1, 7, t + 1, 0, 0);
        idle(5, 0);
        chk(deq_valid == 1 && deq_tag == 8'd7, "R7 held under stall", int'(deq_tag), 7);
        cyc(0, 0, 0, 0, 1);
        chk(empty == 1, "R7 removed on handshake", int'(empty), 1);

        // Late request
        cyc(1, 8, t - 1, 0, 0);
        chk(late_err == 1 && empty == 1, "R8 late dropped", int'(late_err), 1);
        idle(1, 0);
        chk(late_err == 0, "R8 single pulse", int'(late_err), 0);

        // No-response request, both late and on time
        cyc(1, 9, t - 1, 1, 0);
        chk(late_err == 0 && empty == 1, "R9 discarded late", int'(late_err), 0);
        cyc(1, 10, t + 3, 1, 0);
        chk(empty == 1 && overflow == 0, "R9 discarded on time", int'(empty), 1);

        // Capacity
        b = t;
        for (int k = 0; k < DEPTH; k++) cyc(1, 20 + k, b + 40, 0, 0);
        chk(full == 1, "R11 full at DEPTH", int'(full), 1);
        cyc(1, 99, b + 41, 0, 0);
        chk(overflow == 1 && full == 1, "R10 refused when full", int'(overflow), 1);
        while (!deq_valid && t < b + 100) cyc(0, 0, 0, 0, 0);
        cyc(1, 50, t + 2, 0, 1);
        chk(overflow == 0 && full == 1, "R10 accepted with pop", int'(overflow), 0);
        chk(deq_tag == 8'd21, "R7 next head after pop", int'(deq_tag), 21);
        popped.delete();
        while (!empty && t < b + 200) cyc(0, 0, 0, 0, 1);
        chk(popped.size() == DEPTH && popped[DEPTH-1] == 50, "R3 late arrival last", popped.size(), DEPTH);

        // Mixed traffic against the model
        for (int k = 0; k < 600; k++) begin
            bit ev, nr, rd;
            int tm;
            ev = ($urandom_range(0, 99) < 55);
            nr = ($urandom_range(0, 9) == 0);
            rd = ($urandom_range(0, 9) < 5);
            tm = t + $urandom_range(0, 12);
            if ($urandom_range(0, 9) == 0) tm = t - 1;
            cyc(ev, $urandom_range(0, 255), tm, nr, rd);
        end
        idle(30, 1);
        compare();

        done = 1;
        summary();
        $finish;
    end
endmodule